// File: doc/BRIEF.md
# Event Counter with Selectable Timer Clock

The block counts edges on an external event pin in a 16-bit accumulator and can also drive a free-running 16-bit timer counter. The timer's advance pulse comes from one of four sources: a plain divide-by-N prescaler tick, each accumulator event, or one of two taps of a free-running event divider (by 256 or by 65536). A second event pin feeds a narrow cascaded channel, and the wrap of that channel also raises the overflow flag.

Software reaches the block through three registers: the event count, a two-bit flag register and an eight-bit control register. An interrupt request is raised while a flag is set and its enable is set. An optional fast-clear mode clears both flags on any access to the count register.

Top module: `pacc_timer_top`

## Requirements
- R1: After reset the count, flags, control and timer value all read zero, and the interrupt output is low.
- R2: With control bit 0 (accumulate enable) set, each active edge of the event pin increments the count and sets flag bit 0. Control bit 1 selects rising edges (1) or falling edges (0). With bit 0 clear, no edge counts or sets a flag.
- R3: Register address 0 reads the count, and a write there loads it. Address 1 reads the flags and address 2 reads the control byte in bits 7:0. Address 3 reads zero.
- R4: An event that takes the count from 0xFFFF to 0x0000 sets flag bit 1 (overflow).
- R5: The cascaded channel counts active edges on the auxiliary pin under the same enable and polarity. Its wrap from all ones to zero sets flag bit 1.
- R6: Writing 1 to a flag bit at address 1 clears that bit, and writing 0 leaves it unchanged. A hardware set in the same cycle as a clear leaves the flag set.
- R7: With control bit 6 (fast clear) set, any read or write of address 0 clears both flags. With bit 6 clear, a read of address 0 leaves the flags unchanged.
- R8: The interrupt output is high exactly while (flag bit 1 and control bit 2) or (flag bit 0 and control bit 3) holds.
- R9: Control bits 5:4 equal to 00 select the prescaler tick: one timer step every PRESC_DIV cycles. The prescaler is also used whenever accumulate enable is clear, whatever bits 5:4 say.
- R10: Bits 5:4 equal to 01 step the timer once per event. 10 steps it once per 2^LO_BITS events, and 11 once per 2^HI_BITS events. A new selection applies from the cycle after the write.
- R11: With control bit 7 (timer enable) clear, the timer value holds and the prescaler produces no ticks.
- R12: Flag register bits above bit 1 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Event pin of the 16-bit accumulator, asynchronous |
| aux_evt_i | input | 1 | Event pin of the cascaded narrow channel, asynchronous |
| reg_addr_i | input | 2 | Register select: 0 count, 1 flags, 2 control |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |
| timer_o | output | 16 | Timer counter value |

## Verification
The bench builds the block with LO_BITS=2, HI_BITS=4 and PRESC_DIV=4, so the two divider taps fire every 4 and every 16 events and the prescaler ticks every 4 cycles. With these values each timer source can be checked exactly over short windows: every 40-cycle window holds ten prescaler steps, and every 8 or 32 events hold two tap steps, whatever the starting phase. The 16-bit wrap is reached by preloading 0xFFFE. The cascaded channel keeps its default width of 8, so its wrap is checked after 255 and after 256 events.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam logic [1:0] ADDR_CNT = 2'd0;
  localparam logic [1:0] ADDR_FLG = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;

  typedef enum logic [1:0] {
    SRC_PRESC  = 2'd0,
    SRC_EVT    = 2'd1,
    SRC_DIV_LO = 2'd2,
    SRC_DIV_HI = 2'd3
  } clk_src_e;

  typedef struct packed {
    logic     tmr_en;
    logic     fast_clr;
    clk_src_e clk_sel;
    logic     edge_ie;
    logic     ovf_ie;
    logic     rise_sel;
    logic     acc_en;
  } ctl_t;
endpackage

// File: rtl/pacc_edge_sync.sv
module pacc_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = rise_sel_i ? (s2_q & ~s3_q) : (~s2_q & s3_q);
endmodule

// File: rtl/pacc_clk_src.sv
module pacc_clk_src
  import pacc_pkg::*;
#(
  parameter int LO_BITS   = 8,
  parameter int HI_BITS   = 16,
  parameter int PRESC_DIV = 64
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     evt_i,
  input  logic     acc_en_i,
  input  logic     tmr_en_i,
  input  clk_src_e sel_i,
  output logic     tick_o
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESC_DIV - 1);

  logic               presc_tick;
  logic [HI_BITS-1:0] div_q;
  logic               tap_lo, tap_hi;

  generate
    if (PRESC_DIV > 1) begin : g_presc
      logic [PW-1:0] pc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            pc_q <= '0;
        else if (!tmr_en_i)     pc_q <= '0;
        else if (pc_q == PLAST) pc_q <= '0;
        else                    pc_q <= pc_q + 1'b1;
      end
      assign presc_tick = tmr_en_i && (pc_q == PLAST);

      // R9
      presc_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        presc_tick |=> !presc_tick);
    end else begin : g_nopresc
      assign presc_tick = tmr_en_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (evt_i) div_q <= div_q + 1'b1;
  end

  assign tap_lo = evt_i & (&div_q[LO_BITS-1:0]);
  assign tap_hi = evt_i & (&div_q);

  always_comb begin
    if (!acc_en_i) tick_o = presc_tick;
    else begin
      unique case (sel_i)
        SRC_PRESC:  tick_o = presc_tick;
        SRC_EVT:    tick_o = evt_i;
        SRC_DIV_LO: tick_o = tap_lo;
        default:    tick_o = tap_hi;
      endcase
    end
  end

  // R10
  tap_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_hi |-> tap_lo);
  // R11
  presc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_en_i |-> !presc_tick);
endmodule

// File: rtl/pacc_tmr_cnt.sv
module pacc_tmr_cnt #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  output logic [TMR_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (en_i && tick_i) cnt_o <= cnt_o + 1'b1;
  end

  // R11
  tmr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_o));
endmodule

// File: rtl/pacc_timer_top.sv
module pacc_timer_top
  import pacc_pkg::*;
#(
  parameter int ACC_W     = 16,
  parameter int AUX_W     = 8,
  parameter int LO_BITS   = 8,
  parameter int HI_BITS   = 16,
  parameter int PRESC_DIV = 64,
  parameter int TMR_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             aux_evt_i,
  input  logic [1:0]       reg_addr_i,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [ACC_W-1:0] reg_wdata_i,
  output logic [ACC_W-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic [TMR_W-1:0] timer_o
);
  localparam int NCH = 2;

  ctl_t             ctl_q;
  logic [ACC_W-1:0] acc_q;
  logic [AUX_W-1:0] aux_q;
  logic [1:0]       flg_q, flg_set, flg_clr;
  logic [NCH-1:0]   pins, edges;
  logic             acc_ev, aux_ev, acc_wrap, aux_wrap;
  logic             cnt_wr, cnt_touch, flg_wr, ctl_wr;
  logic             tmr_tick;

  assign pins = {aux_evt_i, evt_i};

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_sync
      pacc_edge_sync u_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_i      (pins[i]),
        .rise_sel_i (ctl_q.rise_sel),
        .edge_o     (edges[i])
      );
    end
  endgenerate

  assign acc_ev = edges[0] & ctl_q.acc_en;
  assign aux_ev = edges[1] & ctl_q.acc_en;

  assign cnt_wr    = reg_we_i && reg_addr_i == ADDR_CNT;
  assign cnt_touch = (reg_we_i || reg_re_i) && reg_addr_i == ADDR_CNT;
  assign flg_wr    = reg_we_i && reg_addr_i == ADDR_FLG;
  assign ctl_wr    = reg_we_i && reg_addr_i == ADDR_CTL;

  assign acc_wrap = acc_ev && !cnt_wr && (&acc_q);
  assign aux_wrap = aux_ev && (&aux_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (cnt_wr)  acc_q <= reg_wdata_i;
    else if (acc_ev)  acc_q <= acc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     aux_q <= '0;
    else if (aux_ev) aux_q <= aux_q + 1'b1;
  end

  always_comb begin
    flg_set = {acc_wrap | aux_wrap, acc_ev};
    flg_clr = flg_wr ? reg_wdata_i[1:0] : 2'b00;
    if (ctl_q.fast_clr && cnt_touch) flg_clr = 2'b11;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~flg_clr) | flg_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_t'(reg_wdata_i[7:0]);
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CNT: reg_rdata_o = acc_q;
      ADDR_FLG: reg_rdata_o = ACC_W'(flg_q);
      ADDR_CTL: reg_rdata_o = ACC_W'(ctl_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = (flg_q[1] & ctl_q.ovf_ie) | (flg_q[0] & ctl_q.edge_ie);

  pacc_clk_src #(
    .LO_BITS   (LO_BITS),
    .HI_BITS   (HI_BITS),
    .PRESC_DIV (PRESC_DIV)
  ) u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (acc_ev),
    .acc_en_i (ctl_q.acc_en),
    .tmr_en_i (ctl_q.tmr_en),
    .sel_i    (ctl_q.clk_sel),
    .tick_o   (tmr_tick)
  );

  pacc_tmr_cnt #(.TMR_W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctl_q.tmr_en),
    .tick_i (tmr_tick),
    .cnt_o  (timer_o)
  );

  // R2
  edge_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ev |=> flg_q[0]);
  // R4
  acc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ev && !cnt_wr && acc_q == '1) |=> (acc_q == '0 && flg_q[1]));
  // R6
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg_wr && reg_wdata_i[0] && !acc_ev) |=> !flg_q[0]);
  // R2
  no_count_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q.acc_en && !cnt_wr) |=> $stable(acc_q));
endmodule

// File: tb/pacc_timer_top_test.sv
module pacc_timer_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt = 1'b0, aux_evt = 1'b0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic [15:0] timer;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pacc_timer_top #(.LO_BITS(2), .HI_BITS(4), .PRESC_DIV(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .aux_evt_i(aux_evt),
    .reg_addr_i(addr), .reg_we_i(we), .reg_re_i(re), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .timer_o(timer));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt = ~evt; repeat (3) @(negedge clk);
      evt = ~evt; repeat (4) @(negedge clk);
    end
  endtask

  task automatic aux_pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); aux_evt = 1'b1; repeat (3) @(negedge clk);
      aux_evt = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  // control: b7 tmr_en, b6 fast_clr, b5:4 sel, b3 edge_ie, b2 ovf_ie, b1 rise, b0 en
  task automatic t_reset();
    logic [15:0] d;
    @(negedge clk);
    check("R1 timer", timer, 0);
    check("R1 irq", irq, 0);
    rd(0, d); check("R1 count", d, 0);
    rd(1, d); check("R1 flags", d, 0);
    rd(2, d); check("R1 control", d, 0);
  endtask

  task automatic t_edges();
    logic [15:0] d;
    pulse(2);
    rd(0, d); check("R2 disabled no count", d, 0);
    rd(1, d); check("R2 disabled no flag", d, 0);
    wr(2, 16'h0003);
    pulse(3);
    rd(0, d); check("R2 rising count", d, 3);
    rd(1, d); check("R2 edge flag", d, 1);
    rd(2, d); check("R3 control readback", d, 16'h0003);
    rd(3, d); check("R3 addr3 zero", d, 0);
    wr(2, 16'h0000); @(negedge clk); evt = 1'b1; repeat (5) @(negedge clk);
    wr(2, 16'h0001);
    @(negedge clk); evt = 1'b0; repeat (5) @(negedge clk);
    rd(0, d); check("R2 falling count", d, 4);
    evt = 1'b1; repeat (5) @(negedge clk);
    rd(0, d); check("R2 falling ignores rise", d, 4);
    evt = 1'b0; repeat (5) @(negedge clk);
    wr(2, 16'h0003);
  endtask

  task automatic t_regs_wrap();
    logic [15:0] d;
    wr(1, 16'hFFFF);
    rd(1, d); check("R6 w1c all", d, 0);
    wr(0, 16'hFFFE);
    rd(0, d); check("R3 count load", d, 16'hFFFE);
    pulse(1);
    rd(1, d); check("R4 no ovf before wrap", d, 1);
    pulse(1);
    rd(0, d); check("R4 count wrapped", d, 0);
    rd(1, d); check("R4 ovf flag", d, 3);
    wr(1, 16'h0001);
    rd(1, d); check("R6 clear bit0 keep bit1", d, 2);
    check("R12 upper flag bits", d[15:2], 0);
    wr(1, 16'h0002);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    @(negedge clk); evt = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 1; wdata = 16'h0001; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(1, d); check("R6 set beats clear", d, 1);
    evt = 1'b0; repeat (5) @(negedge clk);
    wr(1, 16'h0003);
  endtask

  task automatic t_fast_irq();
    logic [15:0] d;
    pulse(1);
    rd(0, d);
    rd(1, d); check("R7 read without fast clear", d, 1);
    @(negedge clk); check("R8 irq off when disabled", irq, 0);
    wr(2, 16'h000B);
    @(negedge clk); check("R8 irq edge enabled", irq, 1);
    wr(2, 16'h0007);
    @(negedge clk); check("R8 edge flag ovf_ie only", irq, 0);
    wr(2, 16'h0043);
    rd(0, d);
    rd(1, d); check("R7 fast clear on read", d, 0);
    pulse(1);
    wr(0, 16'h0010);
    rd(1, d); check("R7 fast clear on write", d, 0);
    wr(2, 16'h0003);
  endtask

  task automatic t_timer();
    logic [15:0] t0;
    wr(2, 16'h0083);
    @(negedge clk); t0 = timer; repeat (40) @(negedge clk);
    check("R9 prescaler rate", timer - t0, 10);
    wr(2, 16'h0092);
    @(negedge clk); t0 = timer; repeat (40) @(negedge clk);
    check("R9 prescaler when acc disabled", timer - t0, 10);
    wr(2, 16'h0093);
    @(negedge clk); t0 = timer; pulse(5);
    check("R10 per event", timer - t0, 5);
    wr(2, 16'h00A3);
    @(negedge clk); t0 = timer; pulse(8);
    check("R10 low tap", timer - t0, 2);
    wr(2, 16'h00B3);
    @(negedge clk); t0 = timer; pulse(32);
    check("R10 high tap", timer - t0, 2);
    wr(2, 16'h0013);
    @(negedge clk); t0 = timer; pulse(3); repeat (20) @(negedge clk);
    check("R11 timer frozen", timer - t0, 0);
    wr(2, 16'h0003);
    @(negedge clk); t0 = timer; repeat (20) @(negedge clk);
    check("R11 prescaler stopped", timer - t0, 0);
  endtask

  task automatic t_aux();
    logic [15:0] d;
    wr(1, 16'h0003);
    aux_pulse(255);
    rd(1, d); check("R5 no ovf at 255", d, 0);
    aux_pulse(1);
    rd(1, d); check("R5 aux wrap ovf", d, 2);
    wr(2, 16'h0007);
    @(negedge clk); check("R8 irq ovf", irq, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edges();
    t_regs_wrap();
    t_set_wins();
    t_fast_irq();
    t_timer();
    t_aux();
    finish_run();
  end
endmodule